// File: doc/BRIEF.md
# Binary and Decimal Flag-Setting ALU

This block is the arithmetic and logic unit of an 8-bit accumulator machine. It takes the accumulator, a second operand, a carry input, a decimal-mode select and an operation code. It returns the 8-bit result, the next value of the four condition flags (negative, overflow, zero, carry), a per-flag write mask, and a strobe that says whether the result should be written back. The result path has no registers. The block also holds a four-bit flag register, which takes the masked flag update on each clock edge where `op_valid` is high.

Addition and subtraction run in either binary or packed-BCD form, chosen by `dec_mode`. The carry flag is active-high for both, so on subtraction C=1 means no borrow. Compare and bit test leave the result unwritten and update only their flags. Logical operations, shifts and rotates act on the accumulator. Shifts and rotates ignore the operand.

All control pins are plain levels. `op_valid` is a single-cycle commit strobe, not a handshake. The block never stalls, so there is no back-pressure: a caller may raise `op_valid` on every cycle. Sequencing, the register file and memory access belong to the surrounding design.

Top module: `bcd_alu`

## Requirements
- R1: With op_code 0 (add) and dec_mode low, result is (acc + opnd + carry) mod 256. C is bit 8 of that sum. V is bit 7 of (R^acc)&(R^opnd). N is result bit 7 and Z is high when the result is zero. result_we is high and all four flags are in the mask.
- R2: With op_code 0 and dec_mode high, the low digits are summed with the carry, and the sum is raised by 6 if it exceeds 9, carrying into the high digits. The high-digit sum is corrected the same way, and C is set when that sum exceeds 9. V uses the R1 rule on {uncorrected high sum, corrected low digit}. N and Z come from the final result.
- R3: With op_code 1 (subtract), the block computes acc + ~opnd + carry. N, Z, C and V (V from (R^acc)&(R^~opnd)) always come from that binary value, in either mode. In binary mode the result is that value.
- R4: With op_code 1 and dec_mode high, the low digit is lowered by 6 when the low-digit sum gave no carry out of bit 3. The high digit is lowered by 6 when there was no carry out of bit 7.
- R5: With op_code 2 (compare), the block forms acc + ~opnd + 1. It updates only N, Z and C, never V, and result_we is low.
- R6: With op_codes 3, 4 and 5 (AND, OR, XOR), result_we is high, only N and Z are updated, and C and V in the register are kept.
- R7: With op_code 6 (bit test), Z is set when acc & opnd is zero, N takes opnd bit 7 and V takes opnd bit 6. C is kept and result_we is low.
- R8: With op_code 7 (shift left), result is acc<<1. With op_code 9 (rotate left), result is {acc[6:0], carry}. In both, C takes acc bit 7.
- R9: With op_code 8 (shift right), result is acc>>1 and N is 0. With op_code 10 (rotate right), result is {carry, acc[7:1]}. In both, C takes acc bit 0. Shifts and rotates update N, Z and C only.
- R10: The flag register is zero after reset. Its bits are N=3, V=2, Z=1, C=0. On a clock edge with op_valid high, each bit whose mask bit is set takes the new value. Unmasked bits, and all bits when op_valid is low, keep their value.
- R11: op_codes 11 to 15 update no flag and leave result_we low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Commit the masked flag update on this edge |
| op_code | input | 4 | Operation select |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry |
| dec_mode | input | 1 | Packed-BCD add/subtract when high |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result should be written back |
| flag_next | output | 4 | Next N,V,Z,C values |
| flag_mask | output | 4 | Which flags the operation updates |
| flags_q | output | 4 | Registered N,V,Z,C |

## Verification
Random operands with random carry and mode cover the arithmetic, and they include digit values above 9, so the decimal corrections are also exercised on bytes that are not valid BCD. Directed cases are aimed at specific failures. A decimal carry that ripples through both digits exposes a missing high-digit adjust. An equal compare shows whether Z comes from the difference. Subtracting with carry low shows whether C is treated as a borrow. Inputs of 0x80 and 0x01 to the shifts and rotates show which end bit feeds C. Cycles with op_valid low, and a logical operation that follows a carry-setting add, show whether unmasked flags are held.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int FLAGS_W = 4;
  localparam int FN = 3;
  localparam int FV = 2;
  localparam int FZ = 1;
  localparam int FC = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_CMP = 4'd2, OP_AND = 4'd3,
    OP_OR  = 4'd4, OP_XOR = 4'd5, OP_BIT = 4'd6, OP_SHL = 4'd7,
    OP_SHR = 4'd8, OP_ROL = 4'd9, OP_ROR = 4'd10
  } alu_op_e;
endpackage

// File: rtl/bcd_alu_arith.sv
module bcd_alu_arith
  import bcd_alu_pkg::*;
(
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          cin,
  input  logic          dec,
  output logic [DW-1:0] res,
  output logic          n_o,
  output logic          v_o,
  output logic          z_o,
  output logic          c_o
);
  logic          is_add, is_cmp;
  logic [DW-1:0] mm;
  logic          ci;
  logic [DW:0]   bin;
  logic [NW:0]   half;
  logic [NW:0]   lo_sum, hi_sum;
  logic [NW-1:0] lo_adj, hi_adj, sub_lo, sub_hi;
  logic          lo_cy, hi_cy;
  logic [DW-1:0] dec_pre;

  assign is_add = (op == OP_ADD);
  assign is_cmp = (op == OP_CMP);
  assign mm     = is_add ? m : ~m;
  assign ci     = is_cmp ? 1'b1 : cin;
  assign bin    = {1'b0, a} + {1'b0, mm} + {{DW{1'b0}}, ci};
  assign half   = {1'b0, a[NW-1:0]} + {1'b0, mm[NW-1:0]} + {{NW{1'b0}}, ci};

  // decimal add: per-digit correction
  assign lo_sum = {1'b0, a[NW-1:0]} + {1'b0, m[NW-1:0]} + {{NW{1'b0}}, cin};
  assign lo_cy  = (lo_sum > 5'd9);
  assign lo_adj = lo_cy ? (lo_sum[NW-1:0] + 4'd6) : lo_sum[NW-1:0];
  assign hi_sum = {1'b0, a[DW-1:NW]} + {1'b0, m[DW-1:NW]} + {{NW{1'b0}}, lo_cy};
  assign hi_cy  = (hi_sum > 5'd9);
  assign hi_adj = hi_cy ? (hi_sum[NW-1:0] + 4'd6) : hi_sum[NW-1:0];
  assign dec_pre = {hi_sum[NW-1:0], lo_adj};

  // decimal subtract: borrow-driven correction
  assign sub_lo = half[NW] ? bin[NW-1:0] : (bin[NW-1:0] - 4'd6);
  assign sub_hi = bin[DW]  ? bin[DW-1:NW] : (bin[DW-1:NW] - 4'd6);

  always_comb begin
    res = bin[DW-1:0];
    n_o = bin[DW-1];
    z_o = (bin[DW-1:0] == '0);
    c_o = bin[DW];
    v_o = (bin[DW-1] ^ a[DW-1]) & (bin[DW-1] ^ mm[DW-1]);
    if (dec && is_add) begin
      res = {hi_adj, lo_adj};
      n_o = hi_adj[NW-1];
      z_o = ({hi_adj, lo_adj} == '0);
      c_o = hi_cy;
      v_o = (dec_pre[DW-1] ^ a[DW-1]) & (dec_pre[DW-1] ^ m[DW-1]);
    end else if (dec && (op == OP_SUB)) begin
      res = {sub_hi, sub_lo};
    end
  end
endmodule

// File: rtl/bcd_alu_bitops.sv
module bcd_alu_bitops
  import bcd_alu_pkg::*;
(
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] m,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          c_o
);
  always_comb begin
    res = a;
    c_o = 1'b0;
    case (op)
      OP_AND: res = a & m;
      OP_OR:  res = a | m;
      OP_XOR: res = a ^ m;
      OP_SHL: begin res = {a[DW-2:0], 1'b0}; c_o = a[DW-1]; end
      OP_ROL: begin res = {a[DW-2:0], cin};  c_o = a[DW-1]; end
      OP_SHR: begin res = {1'b0, a[DW-1:1]}; c_o = a[0]; end
      OP_ROR: begin res = {cin, a[DW-1:1]};  c_o = a[0]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_alu_flag_reg.sv
module bcd_alu_flag_reg
  import bcd_alu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [FLAGS_W-1:0] nxt,
  input  logic [FLAGS_W-1:0] mask,
  output logic [FLAGS_W-1:0] q
);
  for (genvar b = 0; b < FLAGS_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q[b] <= 1'b0;
      else if (upd && mask[b]) q[b] <= nxt[b];
    end
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(q));
  // R10
  empty_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mask == '0) |=> $stable(q));
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [3:0]         op_code,
  input  logic [DW-1:0]      acc_in,
  input  logic [DW-1:0]      opnd_in,
  input  logic               carry_in,
  input  logic               dec_mode,
  output logic [DW-1:0]      result,
  output logic               result_we,
  output logic [FLAGS_W-1:0] flag_next,
  output logic [FLAGS_W-1:0] flag_mask,
  output logic [FLAGS_W-1:0] flags_q
);
  logic [DW-1:0] ar_res, bo_res;
  logic          ar_n, ar_v, ar_z, ar_c, bo_c;

  bcd_alu_arith u_arith (
    .op(op_code), .a(acc_in), .m(opnd_in), .cin(carry_in), .dec(dec_mode),
    .res(ar_res), .n_o(ar_n), .v_o(ar_v), .z_o(ar_z), .c_o(ar_c)
  );

  bcd_alu_bitops u_bitops (
    .op(op_code), .a(acc_in), .m(opnd_in), .cin(carry_in),
    .res(bo_res), .c_o(bo_c)
  );

  always_comb begin
    result    = acc_in;
    result_we = 1'b0;
    flag_mask = '0;
    flag_next = '0;
    case (op_code)
      OP_ADD, OP_SUB: begin
        result = ar_res; result_we = 1'b1; flag_mask = 4'b1111;
        flag_next = {ar_n, ar_v, ar_z, ar_c};
      end
      OP_CMP: begin
        flag_mask = 4'b1011;
        flag_next = {ar_n, 1'b0, ar_z, ar_c};
      end
      OP_AND, OP_OR, OP_XOR: begin
        result = bo_res; result_we = 1'b1; flag_mask = 4'b1010;
        flag_next = {bo_res[DW-1], 1'b0, bo_res == '0, 1'b0};
      end
      OP_BIT: begin
        flag_mask = 4'b1110;
        flag_next = {opnd_in[DW-1], opnd_in[DW-2], (acc_in & opnd_in) == '0, 1'b0};
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result = bo_res; result_we = 1'b1; flag_mask = 4'b1011;
        flag_next = {bo_res[DW-1], 1'b0, bo_res == '0, bo_c};
      end
      default: ;
    endcase
  end

  bcd_alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .upd(op_valid),
    .nxt(flag_next), .mask(flag_mask), .q(flags_q)
  );

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_CMP) |-> (!result_we && !flag_mask[FV]));
  // R6
  logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code inside {OP_AND, OP_OR, OP_XOR}) |-> (!flag_mask[FC] && !flag_mask[FV]));
  // R9
  shr_clears_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_SHR) |-> (!flag_next[FN] && flag_next[FC] == acc_in[0]));
  // R11
  spare_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 4'd10) |-> (flag_mask == '0 && !result_we));
  // R7
  bit_test_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_BIT && op_valid) |=> (flags_q[FN] == $past(opnd_in[7]) && flags_q[FV] == $past(opnd_in[6])));
endmodule

// File: tb/test_bcd_alu.sv
module test_bcd_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic       carry_in = 1'b0, dec_mode = 1'b0;
  logic [7:0] result;
  logic       result_we;
  logic [3:0] flag_next, flag_mask, flags_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [3:0] exp_flags = '0;

  always #4 clk = ~clk;

  bcd_alu i_bcd_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in), .dec_mode(dec_mode),
    .result(result), .result_we(result_we), .flag_next(flag_next),
    .flag_mask(flag_mask), .flags_q(flags_q)
  );

  // model: {we, mask, next, result}
  function automatic logic [16:0] model(input int op, input int a, input int m,
                                        input int c, input int d);
    int r = a, we = 0, mk = 0, fn = 0, fv = 0, fz = 0, fc = 0;
    int s, lo, hi, lc, pre, nm, h, cc;
    case (op)
      0: begin
        we = 1; mk = 15;
        if (d == 0) begin
          s = a + m + c; r = s & 255; fc = (s >> 8) & 1;
          fv = (((r ^ a) & (r ^ m)) >> 7) & 1;
        end else begin
          lo = (a & 15) + (m & 15) + c; lc = (lo > 9) ? 1 : 0;
          if (lc != 0) lo = lo + 6;
          hi = (a >> 4) + (m >> 4) + lc;
          pre = ((hi & 15) << 4) | (lo & 15);
          fv = (((pre ^ a) & (pre ^ m)) >> 7) & 1;
          fc = (hi > 9) ? 1 : 0;
          if (fc != 0) hi = hi + 6;
          r = ((hi & 15) << 4) | (lo & 15);
        end
        fn = (r >> 7) & 1; fz = (r == 0) ? 1 : 0;
      end
      1, 2: begin
        cc = (op == 2) ? 1 : c;
        nm = m ^ 255; s = a + nm + cc; h = (a & 15) + (nm & 15) + cc;
        r = s & 255; fc = (s >> 8) & 1;
        fv = (((r ^ a) & (r ^ nm)) >> 7) & 1;
        fn = (r >> 7) & 1; fz = (r == 0) ? 1 : 0;
        if (op == 1) begin
          we = 1; mk = 15;
          if (d != 0) begin
            lo = (h > 15) ? (r & 15) : (((r & 15) - 6) & 15);
            hi = (fc != 0) ? (r >> 4) : (((r >> 4) - 6) & 15);
            r = (hi << 4) | lo;
          end
        end else begin
          mk = 11; fv = 0; r = a;
        end
      end
      3, 4, 5: begin
        r = (op == 3) ? (a & m) : (op == 4) ? (a | m) : (a ^ m);
        we = 1; mk = 10; fn = (r >> 7) & 1; fz = (r == 0) ? 1 : 0;
      end
      6: begin
        mk = 14; fn = (m >> 7) & 1; fv = (m >> 6) & 1; fz = ((a & m) == 0) ? 1 : 0;
      end
      7, 9: begin
        r = ((a << 1) | ((op == 9) ? c : 0)) & 255; fc = (a >> 7) & 1;
        we = 1; mk = 11; fn = (r >> 7) & 1; fz = (r == 0) ? 1 : 0;
      end
      8, 10: begin
        r = (a >> 1) | ((op == 10) ? (c << 7) : 0); fc = a & 1;
        we = 1; mk = 11; fn = (r >> 7) & 1; fz = (r == 0) ? 1 : 0;
      end
      default: ;
    endcase
    model = {we[0], mk[3:0], fn[0], fv[0], fz[0], fc[0], r[7:0]};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op, input int d);
    case (op)
      0: return d ? "R2" : "R1";
      1: return d ? "R4" : "R3";
      2: return "R5";
      3, 4, 5: return "R6";
      6: return "R7";
      7, 9: return "R8";
      8, 10: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic run_op(input int op, input int a, input int m, input int c,
                        input int d, input bit v);
    logic [16:0] e;
    string rq;
    @(negedge clk);
    op_code = op[3:0]; acc_in = a[7:0]; opnd_in = m[7:0];
    carry_in = c[0]; dec_mode = d[0]; op_valid = v;
    #1;
    e = model(op, a, m, c, d);
    rq = req_of(op, d);
    if (e[16]) check(rq, "result", int'(result), int'(e[7:0]));
    check(rq, "result_we", int'(result_we), int'(e[16]));
    check(rq, "flag_mask", int'(flag_mask), int'(e[15:12]));
    check(rq, "flag_next", int'(flag_next & flag_mask), int'(e[11:8] & e[15:12]));
    if (v) exp_flags = (exp_flags & ~e[15:12]) | (e[11:8] & e[15:12]);
    @(posedge clk); #1;
    check("R10", "flags_q", int'(flags_q), int'(exp_flags));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 check("R10", "reset flags_q", int'(flags_q), 0);
    @(negedge clk) rst_n = 1'b1;
    // directed corners
    run_op(0, 8'h58, 8'h46, 1, 1, 1);  // R2: ripple through both digits -> 05, C=1
    run_op(0, 8'h99, 8'h01, 0, 1, 1);  // R2
    run_op(0, 8'h7f, 8'h01, 0, 0, 1);  // R1 overflow
    run_op(0, 8'hff, 8'h01, 0, 0, 1);  // R1 zero with carry
    run_op(3, 8'hf0, 8'h0f, 0, 0, 1);  // R6: Z set, C and V kept
    run_op(1, 8'h46, 8'h12, 1, 1, 1);  // R4 -> 34
    run_op(1, 8'h40, 8'h13, 1, 1, 1);  // R4 low-digit borrow
    run_op(1, 8'h10, 8'h20, 1, 1, 1);  // R4 high borrow
    run_op(1, 8'h05, 8'h05, 0, 0, 1);  // R3 carry low acts as borrow
    run_op(2, 8'h33, 8'h33, 0, 0, 1);  // R5 equal
    run_op(2, 8'h10, 8'h20, 0, 1, 1);  // R5 less
    run_op(6, 8'h0f, 8'hc0, 0, 0, 1);  // R7
    run_op(7, 8'h80, 0, 1, 0, 1);      // R8
    run_op(9, 8'h80, 0, 1, 0, 1);      // R8
    run_op(8, 8'h01, 0, 1, 0, 1);      // R9
    run_op(10, 8'h01, 0, 1, 0, 1);     // R9
    run_op(12, 8'h55, 8'h55, 1, 0, 1); // R11
    run_op(0, 8'hff, 8'hff, 1, 0, 0);  // R10 hold when op_valid low
    // random mix
    for (int k = 0; k < 3000; k++) begin
      run_op(int'($urandom_range(15)), int'($urandom_range(255)), int'($urandom_range(255)),
             int'($urandom_range(1)), int'($urandom_range(1)), ($urandom_range(7) != 0));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule